// File: doc/BRIEF.md
# 64-bit Integer Execute Unit with 32-bit Word Operations

This block is the combinational integer datapath of a 64-bit RISC-V core. Decode hands it a 5-bit operation code, two 64-bit operands, the address of the current instruction and a 20-bit upper immediate. The block returns one 64-bit result in the same cycle. It covers full-width add, subtract, logic, compare and shift operations. It also covers the 32-bit word operations, whose results are always sign-extended from bit 31, and the load-upper-immediate and pc-relative upper-immediate results.

Register-immediate forms need no codes of their own. Decode puts the sign-extended immediate on `opnd_b` and selects the matching register operation. For example, ADDIW uses the ADDW code, and an immediate word shift uses the SLLW, SRLW or SRAW code with the shift amount in the low bits of `opnd_b`. The block has no state. Fetch, decode, the register file and exceptions are handled elsewhere.

Top module: `rv_int_exu`

## Requirements
- R1: For the word codes ADDW=10, SUBW=11, SLLW=12, SRLW=13 and SRAW=14, bits 63..32 of both operands have no effect on the result. Result bits 63..31 all equal bit 31 of the 32-bit result.
- R2: ADDW returns the low 32 bits of a+b and SUBW returns the low 32 bits of a-b, each sign-extended to 64 bits; overflow is discarded. ADDIW is ADDW with the sign-extended immediate on `opnd_b`, so a zero immediate returns a[31:0] sign-extended.
- R3: ADD=0 returns a+b modulo 2^64 and SUB=1 returns a-b modulo 2^64.
- R4: XOR=5 returns a^b, OR=8 returns a|b and AND=9 returns a&b.
- R5: SLT=3 compares the operands as signed 64-bit values and SLTU=4 compares them as unsigned values. Each returns 64'd1 when a<b and 64'd0 otherwise.
- R6: SLL=2, SRL=6 and SRA=7 shift `opnd_a` by `opnd_b[5:0]`. Bits 63..6 of b are ignored. SLL and SRL fill vacated bits with zeros, and SRA fills them with a[63].
- R7: SLLW, SRLW and SRAW shift a[31:0] by `opnd_b[4:0]` and ignore b bits 63..5. SRAW fills with a[31] and the logical forms fill with zeros. The 32-bit result is sign-extended.
- R8: LUI=15 returns {upper_imm, 12'b0} sign-extended from bit 31.
- R9: AUIPC=16 returns inst_addr plus {upper_imm, 12'b0} sign-extended from bit 31, modulo 2^64.
- R10: Codes 17 to 31 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 5 | Operation code |
| opnd_a | input | 64 | First operand (rs1) |
| opnd_b | input | 64 | Second operand (rs2 or sign-extended immediate) |
| inst_addr | input | 64 | Address of the current instruction |
| upper_imm | input | 20 | Upper immediate for LUI and AUIPC |
| result | output | 64 | Operation result |

## Verification
The bench builds the block with the package widths of a 64-bit datapath over a 32-bit word. This puts the shift-amount edges within reach: 0, 31, 32 and 63 for full-width shifts, and 0 and 31 for word shifts. It also reaches operands whose upper half is deliberately garbage, so it shows whether word operations leak bits 63..32. Sign-crossing compares, word overflow from 0x7fffffff, and upper immediates with bit 19 set or clear exercise the sign-extension paths.

// File: rtl/rv_exu_pkg.sv
package rv_exu_pkg;

    localparam int XLEN  = 64;
    localparam int WLEN  = 32;
    localparam int UIMMW = 20;
    localparam int OPW   = 5;
    localparam int XSHW  = $clog2(XLEN);
    localparam int WSHW  = $clog2(WLEN);

    typedef logic [XLEN-1:0] xword_t;
    typedef logic [WLEN-1:0] hword_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 5'd0,
        OP_SUB   = 5'd1,
        OP_SLL   = 5'd2,
        OP_SLT   = 5'd3,
        OP_SLTU  = 5'd4,
        OP_XOR   = 5'd5,
        OP_SRL   = 5'd6,
        OP_SRA   = 5'd7,
        OP_OR    = 5'd8,
        OP_AND   = 5'd9,
        OP_ADDW  = 5'd10,
        OP_SUBW  = 5'd11,
        OP_SLLW  = 5'd12,
        OP_SRLW  = 5'd13,
        OP_SRAW  = 5'd14,
        OP_LUI   = 5'd15,
        OP_AUIPC = 5'd16
    } exu_op_e;

    typedef struct packed {
        xword_t diff_sum;
        logic   lt_s;
        logic   lt_u;
    } arith_res_t;

    typedef struct packed {
        xword_t x_o;
        xword_t o_o;
        xword_t a_o;
    } logic_res_t;

    function automatic xword_t sext_word(input hword_t w);
        return {{(XLEN-WLEN){w[WLEN-1]}}, w};
    endfunction

    function automatic logic is_word_op(input exu_op_e op);
        return (op == OP_ADDW) || (op == OP_SUBW) || (op == OP_SLLW) ||
               (op == OP_SRLW) || (op == OP_SRAW);
    endfunction

endpackage

// File: rtl/exu_addsub.sv
module exu_addsub
    import rv_exu_pkg::*;
(
    input  xword_t     a,
    input  xword_t     b,
    input  logic       sub,
    output arith_res_t res
);
    logic [XLEN:0] wide;
    xword_t        b_eff;

    always_comb begin
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{XLEN{1'b0}}, sub};
        res.diff_sum = wide[XLEN-1:0];
        // no carry out of a + ~b + 1 means a < b unsigned
        res.lt_u = ~wide[XLEN];
        res.lt_s = (a[XLEN-1] ^ b[XLEN-1]) ? a[XLEN-1] : wide[XLEN-1];
    end
endmodule

// File: rtl/exu_logic.sv
module exu_logic
    import rv_exu_pkg::*;
(
    input  xword_t     a,
    input  xword_t     b,
    output logic_res_t res
);
    always_comb begin
        res.x_o = a ^ b;
        res.o_o = a | b;
        res.a_o = a & b;
    end
endmodule

// File: rtl/exu_barrel.sv
module exu_barrel #(
    parameter int W  = 64,
    parameter int AW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [AW-1:0] amt,
    input  logic          to_left,
    input  logic          arith,
    output logic [W-1:0]  out
);
    logic [W-1:0] stg [AW+1];
    logic [W-1:0] pre;
    logic         fill;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            pre[i] = to_left ? val[W-1-i] : val[i];
        end
        fill = arith & ~to_left & val[W-1];
    end

    assign stg[0] = pre;

    genvar k;
    generate
        for (k = 0; k < AW; k++) begin : g_stage
            localparam int SH = 1 << k;
            assign stg[k+1] = amt[k] ? {{SH{fill}}, stg[k][W-1:SH]} : stg[k];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < W; i++) begin
            out[i] = to_left ? stg[AW][W-1-i] : stg[AW][i];
        end
    end
endmodule

// File: rtl/rv_int_exu.sv
module rv_int_exu
    import rv_exu_pkg::*;
(
    input  logic [OPW-1:0]   op_sel,
    input  logic [XLEN-1:0]  opnd_a,
    input  logic [XLEN-1:0]  opnd_b,
    input  logic [XLEN-1:0]  inst_addr,
    input  logic [UIMMW-1:0] upper_imm,
    output logic [XLEN-1:0]  result
);
    exu_op_e    op;
    arith_res_t ar;
    logic_res_t lr;
    logic       do_sub;
    logic       sh_left, sh_arith;
    xword_t     full_sh;
    hword_t     word_sh;
    xword_t     uimm_ext;
    xword_t     pc_rel;

    assign op       = exu_op_e'(op_sel);
    assign do_sub   = (op == OP_SUB) || (op == OP_SUBW) || (op == OP_SLT) || (op == OP_SLTU);
    assign sh_left  = (op == OP_SLL) || (op == OP_SLLW);
    assign sh_arith = (op == OP_SRA) || (op == OP_SRAW);
    assign uimm_ext = {{(XLEN-32){upper_imm[UIMMW-1]}}, upper_imm, 12'b0};
    assign pc_rel   = inst_addr + uimm_ext;

    exu_addsub u_addsub (.a(opnd_a), .b(opnd_b), .sub(do_sub), .res(ar));
    exu_logic  u_logic  (.a(opnd_a), .b(opnd_b), .res(lr));

    exu_barrel #(.W(XLEN)) u_full_sh (
        .val(opnd_a), .amt(opnd_b[XSHW-1:0]), .to_left(sh_left),
        .arith(sh_arith), .out(full_sh)
    );
    exu_barrel #(.W(WLEN)) u_word_sh (
        .val(opnd_a[WLEN-1:0]), .amt(opnd_b[WSHW-1:0]), .to_left(sh_left),
        .arith(sh_arith), .out(word_sh)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_SUB:           result = ar.diff_sum;
            OP_SLT:                   result = {{(XLEN-1){1'b0}}, ar.lt_s};
            OP_SLTU:                  result = {{(XLEN-1){1'b0}}, ar.lt_u};
            OP_XOR:                   result = lr.x_o;
            OP_OR:                    result = lr.o_o;
            OP_AND:                   result = lr.a_o;
            OP_SLL, OP_SRL, OP_SRA:   result = full_sh;
            OP_ADDW, OP_SUBW:         result = sext_word(ar.diff_sum[WLEN-1:0]);
            OP_SLLW, OP_SRLW, OP_SRAW: result = sext_word(word_sh);
            OP_LUI:                   result = uimm_ext;
            OP_AUIPC:                 result = pc_rel;
            default:                  result = '0;
        endcase
    end

    always_comb begin
        if (is_word_op(op)) begin
            p_word_sext_r1: assert (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}})
                else $error("R1 word result not sign-extended");
        end
        if (op == OP_ADDW && opnd_b == '0) begin
            p_addiw_zero_r2: assert (result == sext_word(opnd_a[WLEN-1:0]))
                else $error("R2 zero-immediate word add wrong");
        end
        if (op == OP_SLT || op == OP_SLTU) begin
            p_cmp_bool_r5: assert (result[XLEN-1:1] == '0)
                else $error("R5 compare result not boolean");
        end
        if (op == OP_SLL && opnd_b[XSHW-1:0] == '0) begin
            p_sll_zero_r6: assert (result == opnd_a)
                else $error("R6 zero shift altered operand");
        end
        if (op == OP_LUI) begin
            p_lui_low_r8: assert (result[11:0] == 12'b0)
                else $error("R8 upper immediate low bits nonzero");
        end
        if (op == OP_AUIPC && upper_imm == '0) begin
            p_auipc_zero_r9: assert (result == inst_addr)
                else $error("R9 zero upper immediate moved address");
        end
    end
endmodule

// File: tb/tb_rv_int_exu.sv
module tb_rv_int_exu;
    import rv_exu_pkg::*;

    logic         clk = 1'b0;
    logic [4:0]   op_sel = '0;
    logic [63:0]  opnd_a = '0, opnd_b = '0, inst_addr = '0;
    logic [19:0]  upper_imm = '0;
    logic [63:0]  result;
    int           n_checks = 0;
    int           n_err = 0;
    int           cycles = 0;

    always #4 clk = ~clk;

    rv_int_exu dut (
        .op_sel(op_sel), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .inst_addr(inst_addr), .upper_imm(upper_imm), .result(result)
    );

    function automatic logic [63:0] sx(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    function automatic logic [63:0] ref_model(input logic [4:0] o, input logic [63:0] a,
                                              input logic [63:0] b, input logic [63:0] pc,
                                              input logic [19:0] ui);
        logic [31:0] w;
        logic [63:0] u;
        u = sx({ui, 12'b0});
        case (o)
            5'd0:  return a + b;
            5'd1:  return a - b;
            5'd2:  return a << b[5:0];
            5'd3:  return ($signed(a) < $signed(b)) ? 64'd1 : 64'd0;
            5'd4:  return (a < b) ? 64'd1 : 64'd0;
            5'd5:  return a ^ b;
            5'd6:  return a >> b[5:0];
            5'd7:  return $signed(a) >>> b[5:0];
            5'd8:  return a | b;
            5'd9:  return a & b;
            5'd10: begin w = a[31:0] + b[31:0]; return sx(w); end
            5'd11: begin w = a[31:0] - b[31:0]; return sx(w); end
            5'd12: begin w = a[31:0] << b[4:0]; return sx(w); end
            5'd13: begin w = a[31:0] >> b[4:0]; return sx(w); end
            5'd14: begin w = $signed(a[31:0]) >>> b[4:0]; return sx(w); end
            5'd15: return u;
            5'd16: return pc + u;
            default: return 64'd0;
        endcase
    endfunction

    task automatic run(input string tag, input logic [4:0] o, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] pc, input logic [19:0] ui);
        logic [63:0] exp;
        @(posedge clk);
        op_sel = o; opnd_a = a; opnd_b = b; inst_addr = pc; upper_imm = ui;
        exp = ref_model(o, a, b, pc, ui);
        @(negedge clk);
        n_checks++;
        if (result !== exp) begin
            n_err++;
            $display("FAIL %s op=%0d actual=%h expected=%h", tag, o, result, exp);
        end
    endtask

    task automatic t_idle;  // R3 quiescent result with all-zero inputs
        run("R3", 5'd0, 64'd0, 64'd0, 64'd0, 20'd0);
    endtask

    task automatic t_full_arith;
        run("R3", OP_ADD, 64'hffff_ffff_ffff_ffff, 64'd1, 0, 0);
        run("R3", OP_ADD, 64'h0123_4567_89ab_cdef, 64'h1111_2222_3333_4444, 0, 0);
        run("R3", OP_SUB, 64'd0, 64'd1, 0, 0);
        run("R3", OP_SUB, 64'h8000_0000_0000_0000, 64'h7fff_ffff_ffff_ffff, 0, 0);
    endtask

    task automatic t_logic;
        run("R4", OP_XOR, 64'hf0f0_1234_aaaa_5555, 64'h0ff0_ffff_5555_5555, 0, 0);
        run("R4", OP_OR,  64'hf0f0_1234_aaaa_0000, 64'h0ff0_0000_5555_0001, 0, 0);
        run("R4", OP_AND, 64'hf0f0_1234_aaaa_ffff, 64'h0ff0_ff00_5555_0f0f, 0, 0);
    endtask

    task automatic t_compare;
        run("R5", OP_SLT,  64'hffff_ffff_ffff_ffff, 64'd1, 0, 0);
        run("R5", OP_SLTU, 64'hffff_ffff_ffff_ffff, 64'd1, 0, 0);
        run("R5", OP_SLT,  64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 0, 0);
        run("R5", OP_SLTU, 64'h7fff_ffff_ffff_ffff, 64'h8000_0000_0000_0000, 0, 0);
        run("R5", OP_SLT,  64'd5, 64'd5, 0, 0);
        run("R5", OP_SLTU, 64'd4, 64'd5, 0, 0);
    endtask

    task automatic t_full_shift;
        run("R6", OP_SLL, 64'h8000_0000_0000_0001, 64'd0, 0, 0);
        run("R6", OP_SLL, 64'h0000_0000_0000_0003, 64'hffff_ff00_0000_003f, 0, 0);
        run("R6", OP_SRL, 64'h8000_0000_0000_0000, 64'd32, 0, 0);
        run("R6", OP_SRA, 64'h8000_0000_0000_0000, 64'd63, 0, 0);
        run("R6", OP_SRA, 64'h4000_0000_0000_0000, 64'h0000_0000_0000_0041, 0, 0);
        run("R6", OP_SRL, 64'hdead_beef_cafe_f00d, 64'd31, 0, 0);
    endtask

    task automatic t_word_shift;
        run("R7", OP_SLLW, 64'hffff_ffff_0000_0001, 64'd31, 0, 0);
        run("R7", OP_SRLW, 64'h1234_5678_8000_0000, 64'hffff_ffff_ffff_ffe4, 0, 0);
        run("R7", OP_SRAW, 64'h0000_0000_8000_0000, 64'd31, 0, 0);
        run("R7", OP_SRAW, 64'hffff_ffff_4000_0000, 64'd30, 0, 0);
        run("R7", OP_SRLW, 64'h0000_0000_8000_0000, 64'd0, 0, 0);
    endtask

    task automatic t_word_arith;
        run("R2", OP_ADDW, 64'h0000_0000_7fff_ffff, 64'd1, 0, 0);
        run("R2", OP_SUBW, 64'd0, 64'd1, 0, 0);
        run("R2", OP_ADDW, 64'h1234_5678_9abc_def0, 64'd0, 0, 0);
        run("R2", OP_ADDW, 64'h0000_0001_0000_0005, 64'hffff_ffff_ffff_fffb, 0, 0);
        // R1 upper operand halves must not matter
        run("R1", OP_ADDW, 64'hdead_beef_0000_0010, 64'hcafe_f00d_0000_0020, 0, 0);
        run("R1", OP_SUBW, 64'haaaa_aaaa_0000_0003, 64'h5555_5555_0000_0001, 0, 0);
    endtask

    task automatic t_upper;
        run("R8", OP_LUI,   64'h1, 64'h2, 64'h3, 20'h80000);
        run("R8", OP_LUI,   64'h1, 64'h2, 64'h3, 20'h7ffff);
        run("R9", OP_AUIPC, 0, 0, 64'h0000_0000_8000_1000, 20'hfffff);
        run("R9", OP_AUIPC, 0, 0, 64'hffff_ffff_ffff_f000, 20'h00001);
        run("R9", OP_AUIPC, 0, 0, 64'h0000_0042_0000_0100, 20'h00000);
    endtask

    task automatic t_unused;
        run("R10", 5'd17, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_ffff, 64'h1, 20'hfffff);
        run("R10", 5'd31, 64'h1234, 64'h5678, 64'h9, 20'h12345);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_err = n_err + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_full_arith();
        t_logic();
        t_compare();
        t_full_shift();
        t_word_shift();
        t_word_arith();
        t_upper();
        t_unused();
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule